// File: doc/BRIEF.md
# Dual-Phase Serial Frame Transmitter

This block turns parallel audio words into a serial bit stream on one data pin. Framing comes from outside: a bit clock and a frame-sync line, each with its own polarity selection, are oversampled by the system clock. A frame sync starts a frame. The frame is one phase long, or two phases when the configuration asks for it. Each phase has its own word length and word count. A programmable data delay sets how many bit periods pass between the detected frame sync and the first data bit. This covers both zero-delay framing (DSP-B style) and one-bit-delay framing (DSP-A style).

Words arrive through a one-word holding register with a valid/ready handshake. Each time a word moves from that register into the shifter, the block pulses a data request. If the holding register is empty at a word boundary, the previous word is sent again. A frame sync that arrives while a frame is still running is a sync error. The error is recorded in a sticky flag and restarts the frame, unless the ignore option is set. The transmitter works only while its enable is high.

Top module: `tx_serial_frame`

## Requirements
- R1: The 3-bit word-length codes at `cfg[7:5]` (phase 1) and `cfg[23:21]` (phase 2) select 0=8, 1=12, 2=16, 3=20, 4=24 and 5=32 bits; codes 6 and 7 also select 32 bits.
- R2: `cfg[14:8]` and `cfg[30:24]` hold the phase-1 and phase-2 word counts minus one.
- R3: With `cfg[31]`=1 a frame sends all phase-1 words and then all phase-2 words; with `cfg[31]`=0 it sends phase 1 only.
- R4: `cfg[17:16]` is the data delay d (value 3 acts as 2). The first data bit is valid in bit period d+1, where period 0 is the one whose sampling edge detects the frame sync.
- R5: Each word is sent MSB first. `sdout` is 0 before the first bit, after the last bit of a frame, and while the block is idle.
- R6: With `clk_pol`=1, data changes after a falling bit-clock edge and frame sync is sampled on the rising edge. With `clk_pol`=0 both edges are swapped.
- R7: The frame sync is active high when `fs_pol`=0 and active low when `fs_pol`=1. Only an inactive-to-active change seen on sampling edges starts a frame, so holding sync active starts just one frame.
- R8: A frame sync detected before the last bit of a frame sets `sync_err`, which stays set while enabled. The frame then restarts with the data delay.
- R9: With `cfg[18]`=1, such an early frame sync is disregarded: the frame continues unchanged and `sync_err` stays 0.
- R10: While `tx_en`=0, `sdout`, `sync_err` and `tx_ready` are 0 and the holding register is emptied.
- R11: `tx_ready` is high while enabled with an empty holding register, and a word is accepted when `tx_valid` and `tx_ready` are both high. `data_req` pulses for one cycle each time a held word moves into the shifter.
- R12: If no word is held at a word boundary, the previous word is sent again and no `data_req` pulse is made.
- R13: `irq` equals `sync_err` when `irq_mode`=3 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bit clock and frame sync are oversampled by it |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| cfg | input | 32 | Frame configuration word |
| clk_pol | input | 1 | Bit-clock edge selection |
| fs_pol | input | 1 | Frame-sync polarity (1 = active low) |
| irq_mode | input | 2 | Interrupt source selection |
| bclk | input | 1 | Bit clock |
| fsync | input | 1 | Frame sync |
| tx_data | input | 32 | Word to transmit |
| tx_valid | input | 1 | Word on tx_data is valid |
| tx_ready | output | 1 | Holding register can accept a word |
| sdout | output | 1 | Serial data out |
| data_req | output | 1 | One-cycle pulse when a held word is consumed |
| sync_err | output | 1 | Sticky frame-sync error flag |
| irq | output | 1 | Interrupt output |

## Verification
The serial stream is sampled at every bit-clock sampling edge and compared bit by bit against frames built from the requirements. The frames use word lengths of 8, 12, 16, 20, 24 and 32 bits, delays of 0, 1 and 3, and both clock and frame-sync polarities, so that bit order, phase switching, word counts and gap length can each be told apart. Other patterns cover a frame sync held for several periods, a second sync in mid-frame with and without the ignore option, and a frame with fewer words supplied than it needs. These separate a restart from a continued frame, and a repeated word from a fresh one. The number of data-request pulses per frame shows which words came from the holding register.

// File: rtl/tx_frame_pkg.sv
// Shared types and helpers for the serial frame transmitter.
// Assumes a 32-bit configuration word with fixed field positions.
package tx_frame_pkg;

    localparam int WORD_MAX = 32;
    localparam int CNT_W    = 7;
    localparam int IDX_W    = $clog2(WORD_MAX);
    localparam int LEN_W    = IDX_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_SHIFT = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic             two_phase;
        logic [CNT_W-1:0] cnt2;
        logic [2:0]       wl2;
        logic             ignore;
        logic [1:0]       dly;
        logic [CNT_W-1:0] cnt1;
        logic [2:0]       wl1;
    } tx_cfg_t;

    // Split the configuration word into its fields.
    function automatic tx_cfg_t decode_cfg(input logic [31:0] w);
        tx_cfg_t c;
        c.two_phase = w[31];
        c.cnt2      = w[30:24];
        c.wl2       = w[23:21];
        c.ignore    = w[18];
        c.dly       = w[17:16];
        c.cnt1      = w[14:8];
        c.wl1       = w[7:5];
        return c;
    endfunction

    // Word-length code to number of bits: 8 + 4*code up to code 4, else 32.
    function automatic logic [LEN_W-1:0] code_to_len(input logic [2:0] code);
        logic [LEN_W-1:0] n;
        if (code < 3'd5) n = LEN_W'(8) + LEN_W'({code, 2'b00});
        else             n = LEN_W'(WORD_MAX);
        return n;
    endfunction

endpackage

// File: rtl/tx_edge_det.sv
// Bit-clock and frame-sync edge detection.
// Assumes bclk and fsync are already synchronous to clk and that each
// bit-clock level lasts at least two clk cycles.
module tx_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic clk_pol,
    input  logic fs_pol,
    output logic drive_stb,
    output logic sample_stb,
    output logic fs_det
);
    logic bclk_q;
    logic fs_lvl_q;
    logic rise;
    logic fall;
    logic fs_act;

    assign rise       = bclk & ~bclk_q;
    assign fall       = ~bclk & bclk_q;
    assign sample_stb = clk_pol ? rise : fall;
    assign drive_stb  = clk_pol ? fall : rise;
    assign fs_act     = fsync ^ fs_pol;
    assign fs_det     = sample_stb & fs_act & ~fs_lvl_q;

    // Track the previous bit-clock level and the sync level at sampling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q   <= 1'b0;
            fs_lvl_q <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (sample_stb) fs_lvl_q <= fs_act;
        end
    end
endmodule

// File: rtl/tx_hold_reg.sv
// One-word holding register with a valid/ready write side.
// Emits a one-cycle request pulse when the sequencer takes the held word.
module tx_hold_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              ready,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              req
);
    assign ready = en & ~full;

    // Fill on handshake, drain when the sequencer takes the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            req  <= 1'b0;
        end else if (!en) begin
            full <= 1'b0;
            req  <= 1'b0;
        end else begin
            req <= take & full;
            if (take && full) full <= 1'b0;
            if (wr_valid && ready) begin
                full <= 1'b1;
                data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/tx_frame_seq.sv
// Frame sequencer: data delay, phase and word counting, MSB-first output.
// Assumes the configuration is stable during a frame and that drive and
// sampling strobes never fall in the same cycle.
module tx_frame_seq
    import tx_frame_pkg::*;
#(
    parameter int DATA_W = WORD_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  tx_cfg_t           cfg,
    input  logic              drive_stb,
    input  logic              fs_det,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              sdout,
    output logic              sync_err,
    output logic              busy
);
    seq_state_t        state;
    logic [1:0]        dly_cnt;
    logic              phase;
    logic [CNT_W-1:0]  word_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] cur_word;

    logic [CNT_W-1:0]  cur_cnt;
    logic              word_last;
    logic              phase_last;
    logic              last_bit;
    logic              start_frame;
    logic              err_set;
    logic [1:0]        dly_eff;
    logic              load;
    logic              first;
    logic              nxt_phase;
    logic [CNT_W-1:0]  nxt_wcnt;
    logic [LEN_W-1:0]  nxt_len;
    logic [IDX_W-1:0]  nxt_top;
    logic [DATA_W-1:0] word_in;

    // Frame position and sync decisions.
    always_comb begin
        cur_cnt     = phase ? cfg.cnt2 : cfg.cnt1;
        word_last   = (word_cnt == cur_cnt);
        phase_last  = phase | ~cfg.two_phase;
        busy        = (state != ST_IDLE);
        last_bit    = (state == ST_SHIFT) && (bit_idx == '0) && word_last && phase_last;
        start_frame = fs_det & (~busy | last_bit | ~cfg.ignore);
        err_set     = fs_det & busy & ~last_bit & ~cfg.ignore;
        dly_eff     = (cfg.dly == 2'd3) ? 2'd2 : cfg.dly;
    end

    // Word-load decision and the parameters of the next word.
    always_comb begin
        first     = (state == ST_DELAY);
        load      = drive_stb & ~start_frame &
                    (((state == ST_DELAY) && (dly_cnt == 2'd0)) ||
                     ((state == ST_SHIFT) && (bit_idx == '0) && !last_bit));
        nxt_phase = first ? 1'b0 : (word_last ? 1'b1 : phase);
        nxt_wcnt  = (first || word_last) ? '0 : word_cnt + 1'b1;
        nxt_len   = code_to_len(nxt_phase ? cfg.wl2 : cfg.wl1);
        nxt_top   = IDX_W'(nxt_len - LEN_W'(1));
        word_in   = hold_full ? hold_data : cur_word;
        take      = load & hold_full;
    end

    // Frame state machine and serial output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            dly_cnt  <= 2'd0;
            phase    <= 1'b0;
            word_cnt <= '0;
            bit_idx  <= '0;
            cur_word <= '0;
            sdout    <= 1'b0;
            sync_err <= 1'b0;
        end else if (!en) begin
            state    <= ST_IDLE;
            sdout    <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            if (err_set) sync_err <= 1'b1;
            if (start_frame) begin
                state   <= ST_DELAY;
                dly_cnt <= dly_eff;
            end else if (load) begin
                state    <= ST_SHIFT;
                cur_word <= word_in;
                phase    <= nxt_phase;
                word_cnt <= nxt_wcnt;
                bit_idx  <= nxt_top;
                sdout    <= word_in[nxt_top];
            end else if (drive_stb) begin
                case (state)
                    ST_DELAY: begin
                        dly_cnt <= dly_cnt - 2'd1;
                        sdout   <= 1'b0;
                    end
                    ST_SHIFT: begin
                        if (bit_idx != '0) begin
                            bit_idx <= bit_idx - 1'b1;
                            sdout   <= cur_word[bit_idx - 1'b1];
                        end else begin
                            state <= ST_IDLE;
                            sdout <= 1'b0;
                        end
                    end
                    default: sdout <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tx_serial_frame.sv
// Top of the dual-phase serial frame transmitter.
// Assumes bit clock and frame sync are synchronous to clk and slower than it.
module tx_serial_frame
    import tx_frame_pkg::*;
#(
    parameter int DATA_W = WORD_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [31:0]       cfg,
    input  logic              clk_pol,
    input  logic              fs_pol,
    input  logic [1:0]        irq_mode,
    input  logic              bclk,
    input  logic              fsync,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              sdout,
    output logic              data_req,
    output logic              sync_err,
    output logic              irq
);
    tx_cfg_t           cfg_d;
    logic              drive_stb;
    logic              sample_stb;
    logic              fs_det;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              seq_busy;

    assign cfg_d = decode_cfg(cfg);
    assign irq   = sync_err & (irq_mode == 2'b11);

    tx_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (bclk),
        .fsync      (fsync),
        .clk_pol    (clk_pol),
        .fs_pol     (fs_pol),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb),
        .fs_det     (fs_det)
    );

    tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_en),
        .wr_valid (tx_valid),
        .wr_data  (tx_data),
        .take     (take),
        .ready    (tx_ready),
        .full     (hold_full),
        .data     (hold_data),
        .req      (data_req)
    );

    tx_frame_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .cfg       (cfg_d),
        .drive_stb (drive_stb),
        .fs_det    (fs_det),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .take      (take),
        .sdout     (sdout),
        .sync_err  (sync_err),
        .busy      (seq_busy)
    );
endmodule

// File: rtl/tx_frame_chk.sv
// Property checker for the serial frame transmitter, bound to its top.
module tx_frame_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_en,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       data_req,
    input logic       sync_err,
    input logic       irq,
    input logic [1:0] irq_mode,
    input logic       sdout,
    input logic       busy
);
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && tx_en) |=> sync_err);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> $past(busy));

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!sync_err && !sdout));

    assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sdout);

    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |=> !data_req);

    assert_ready_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    assert_irq_mode_R13: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sync_err && irq_mode == 2'b11));
endmodule

bind tx_serial_frame tx_frame_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .data_req (data_req),
    .sync_err (sync_err),
    .irq      (irq),
    .irq_mode (irq_mode),
    .sdout    (sdout),
    .busy     (seq_busy)
);

// File: tb/tx_serial_frame_test.sv
module tx_serial_frame_test;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic [31:0] cfg = '0;
    logic        clk_pol = 1'b1;
    logic        fs_pol = 1'b0;
    logic [1:0]  irq_mode = 2'b00;
    logic        bclk = 1'b1;
    logic        fsync = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready, sdout, data_req, sync_err, irq;

    int errors = 0;
    int checks = 0;
    int req_cnt = 0;
    bit done = 0;
    logic rec [128];
    logic ex  [128];
    logic [31:0] feed_buf [8];
    int feed_n = 0;

    tx_serial_frame uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cfg(cfg), .clk_pol(clk_pol),
        .fs_pol(fs_pol), .irq_mode(irq_mode), .bclk(bclk), .fsync(fsync),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .sdout(sdout), .data_req(data_req), .sync_err(sync_err), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (data_req) req_cnt++;

    task automatic check_val(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input bit two, input int wl1, input int c1,
                                           input int wl2, input int c2, input int dly,
                                           input bit ign);
        logic [31:0] w = '0;
        w[31] = two; w[30:24] = 7'(c2); w[23:21] = 3'(wl2); w[18] = ign;
        w[17:16] = 2'(dly); w[14:8] = 7'(c1); w[7:5] = 3'(wl1);
        return w;
    endfunction

    task automatic clear_ex();
        for (int i = 0; i < 128; i++) ex[i] = 1'b0;
    endtask

    task automatic place_word(input int pos, input logic [31:0] w, input int len, input int nbits);
        for (int i = 0; i < nbits; i++) ex[pos + i] = w[len - 1 - i];
    endtask

    task automatic setup(input logic [31:0] c, input bit cp, input bit fp, input logic [1:0] im);
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
        cfg = c; clk_pol = cp; bclk = cp; fs_pol = fp; fsync = fp; irq_mode = im;
        repeat (3) @(negedge clk);
        tx_en = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic feeder();
        for (int i = 0; i < feed_n; i++) begin
            @(negedge clk);
            while (!tx_ready) @(negedge clk);
            tx_data = feed_buf[i]; tx_valid = 1'b1;
            @(negedge clk);
            tx_valid = 1'b0;
        end
    endtask

    task automatic run_frame(input int n, input int hold_last, input int second);
        for (int k = 0; k < n; k++) begin
            bclk = ~clk_pol;
            fsync = ((k <= hold_last) || (k == second)) ^ fs_pol;
            repeat (HB) @(negedge clk);
            rec[k] = sdout;
            bclk = clk_pol;
            repeat (HB) @(negedge clk);
        end
        fsync = fs_pol;
    endtask

    task automatic check_stream(input string tag, input int n);
        int bad = -1;
        for (int i = 0; i < n; i++) if (bad < 0 && rec[i] !== ex[i]) bad = i;
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s: bit period %0d got %b expected %b", tag, bad, rec[bad], ex[bad]);
        end
    endtask

    // R10 R5: outputs after reset
    task automatic t_reset();
        check_val("R10 reset tx_ready", 32'(tx_ready), 0);
        check_val("R5 reset sdout", 32'(sdout), 0);
        check_val("R8 reset sync_err", 32'(sync_err), 0);
        check_val("R13 reset irq", 32'(irq), 0);
    endtask

    // R1 R4 R5 R6 R11: one 16-bit word, delay 1
    task automatic t_single16();
        int r0;
        setup(mk_cfg(0, 2, 0, 0, 0, 1, 0), 1'b1, 1'b0, 2'b00);
        check_val("R11 ready when empty", 32'(tx_ready), 1);
        feed_buf[0] = 32'h0000A5C3; feed_n = 1;
        feeder();
        @(negedge clk);
        check_val("R11 ready low when full", 32'(tx_ready), 0);
        r0 = req_cnt;
        run_frame(22, 0, -1);
        clear_ex(); place_word(2, 32'hA5C3, 16, 16);
        check_stream("R1 R4 R5 16-bit delay1", 22);
        check_val("R11 one request", 32'(req_cnt - r0), 1);
    endtask

    // R2 R3 R1: two phases, 2x8 then 1x12, delay 0
    task automatic t_two_phase();
        int r0;
        setup(mk_cfg(1, 0, 1, 1, 0, 0, 0), 1'b1, 1'b0, 2'b00);
        feed_buf[0] = 32'h3C; feed_buf[1] = 32'h81; feed_buf[2] = 32'hABC; feed_n = 3;
        r0 = req_cnt;
        fork feeder(); join_none
        repeat (6) @(negedge clk);
        run_frame(32, 0, -1);
        clear_ex(); place_word(1, 32'h3C, 8, 8); place_word(9, 32'h81, 8, 8);
        place_word(17, 32'hABC, 12, 12);
        check_stream("R2 R3 two-phase frame", 32);
        check_val("R11 three requests", 32'(req_cnt - r0), 3);
    endtask

    // R12: underrun repeats previous 20-bit word
    task automatic t_underrun();
        int r0;
        setup(mk_cfg(0, 3, 1, 0, 0, 1, 0), 1'b1, 1'b0, 2'b00);
        feed_buf[0] = 32'h9ABCD; feed_n = 1;
        feeder();
        r0 = req_cnt;
        run_frame(46, 0, -1);
        clear_ex(); place_word(2, 32'h9ABCD, 20, 20); place_word(22, 32'h9ABCD, 20, 20);
        check_stream("R12 word repeated", 46);
        check_val("R12 single request", 32'(req_cnt - r0), 1);
    endtask

    // R6 R7 R4 R1: inverted edges, active-low sync, delay code 3, 32-bit
    task automatic t_polarity();
        setup(mk_cfg(0, 5, 0, 0, 0, 3, 0), 1'b0, 1'b1, 2'b00);
        feed_buf[0] = 32'hDEADBEEF; feed_n = 1;
        feeder();
        run_frame(38, 0, -1);
        clear_ex(); place_word(3, 32'hDEADBEEF, 32, 32);
        check_stream("R6 R7 R4 inverted edges 32-bit", 38);
    endtask

    // R7: sync held active for four periods starts one frame, 24-bit, delay 0
    task automatic t_held_sync();
        setup(mk_cfg(0, 4, 0, 0, 0, 0, 0), 1'b1, 1'b0, 2'b00);
        feed_buf[0] = 32'h123456; feed_n = 1;
        feeder();
        run_frame(28, 3, -1);
        clear_ex(); place_word(1, 32'h123456, 24, 24);
        check_stream("R7 held sync single frame", 28);
        check_val("R7 no error from held sync", 32'(sync_err), 0);
    endtask

    // R8 R13 R10: early sync restarts frame, error sticky, irq by mode
    task automatic t_sync_error();
        setup(mk_cfg(0, 2, 0, 0, 0, 1, 0), 1'b1, 1'b0, 2'b11);
        feed_buf[0] = 32'hF0F0; feed_buf[1] = 32'h0FF0; feed_n = 2;
        fork feeder(); join_none
        repeat (8) @(negedge clk);
        run_frame(27, 0, 6);
        clear_ex(); place_word(2, 32'hF0F0, 16, 5); place_word(8, 32'h0FF0, 16, 16);
        check_stream("R8 restart after early sync", 27);
        check_val("R8 sync_err set", 32'(sync_err), 1);
        check_val("R13 irq in mode 3", 32'(irq), 1);
        irq_mode = 2'b01;
        @(negedge clk);
        check_val("R13 irq off in mode 1", 32'(irq), 0);
        check_val("R8 sync_err still set", 32'(sync_err), 1);
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        check_val("R10 disable clears error", 32'(sync_err), 0);
    endtask

    // R9: early sync ignored
    task automatic t_ignore();
        setup(mk_cfg(0, 2, 0, 0, 0, 1, 1), 1'b1, 1'b0, 2'b11);
        feed_buf[0] = 32'hF0F0; feed_n = 1;
        feeder();
        run_frame(21, 0, 6);
        clear_ex(); place_word(2, 32'hF0F0, 16, 16);
        check_stream("R9 frame continues", 21);
        check_val("R9 no sync_err", 32'(sync_err), 0);
    endtask

    // R10: disable empties the holding register
    task automatic t_disable();
        setup(mk_cfg(0, 2, 0, 0, 0, 1, 0), 1'b1, 1'b0, 2'b00);
        feed_buf[0] = 32'h5555; feed_n = 1;
        feeder();
        @(negedge clk);
        check_val("R11 holding full", 32'(tx_ready), 0);
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        check_val("R10 ready low when disabled", 32'(tx_ready), 0);
        check_val("R10 sdout low when disabled", 32'(sdout), 0);
        tx_en = 1'b1;
        repeat (2) @(negedge clk);
        check_val("R10 holding emptied", 32'(tx_ready), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single16();
        t_two_phase();
        t_underrun();
        t_polarity();
        t_held_sync();
        t_sync_error();
        t_ignore();
        t_disable();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule